// File: doc/BRIEF.md
# SPI Command-Queue Register Front-End

This block is the host-facing side of a command-driven SPI master. A simple 32-bit register bus lets software queue 16-bit command words and outgoing data bytes, collect incoming data bytes, and find out how much room or data each queue holds. A separate engine, not part of this block, drains the command and outgoing queues and fills the incoming queue through valid/ready handshakes. When the engine finishes a synchronisation command, it strobes an 8-bit marker ID. The block latches that ID so software can tell which queued message has completed.

A four-source interrupt controller sits beside the queues. It has an enable register, a write-one-to-clear pending register and an unmasked source register. The three queue sources are level driven: each keeps setting its pending bit for as long as its queue sits past the threshold. The fourth source is the marker-completion event. A soft-reset register holds the engine in reset and flushes all three queues. A read-only identification word reports the layout revision.

Top module: `spi_cmdq_regif`

## Requirements
- R1: Address 0x00 reads 0x0001_0300, with major revision 1 in bits [23:16], minor 3 in bits [15:8] and patch 0 in bits [7:0]. Any address not listed in these requirements reads 0.
- R2: A write to 0xE0 queues bits [15:0] as a command word, and a write to 0xE4 queues bits [7:0] as an outgoing byte. Each queue presents its entries on its engine-side data output in write order.
- R3: Each queue holds 16 entries. A push into a full queue is dropped, and the stored entries stay intact and in order.
- R4: 0xD0 reads the free command entries and 0xD4 reads the free outgoing entries, each as 16 minus occupancy. 0xD8 reads the incoming occupancy.
- R5: A read of 0xE8 returns the head incoming byte and removes it. A read of 0xEC returns the head without removing it. Both read 0 when the queue is empty, and a read of 0xE8 on an empty queue leaves the occupancy at 0.
- R6: The interrupt conditions are: bit 0, command occupancy at most 4; bit 1, outgoing occupancy at most 4; bit 2, incoming occupancy at least 12; bit 3, marker completion. 0x88 shows bits 0-2 as the live conditions and bit 3 as the latched marker event, with no enable mask.
- R7: Writing 1 to a bit of 0x84 clears that pending bit, and writing 0 leaves it alone. A queue condition that still holds sets its bit again on the next cycle.
- R8: 0x80 bits [3:0] enable the sources. The interrupt output is high exactly when some pending bit has its enable set.
- R9: A marker strobe copies its 8-bit ID into 0xC0 and sets pending bit 3.
- R10: Bit 0 of 0x40 reads 1 after hardware reset. While it is 1: the engine-reset output is high, all three queues are empty, pushes from the bus and the engine are dropped, and both engine-side valids are low. Writing 0 releases the engine.
- R11: Command and outgoing valid mean the queue is not empty, and an entry leaves on valid and ready. Incoming ready is high when the queue is not full and the engine is not held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (needed for the pop side effect) |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request |
| eng_rst_o | output | 1 | Engine soft reset |
| cmd_valid_o | output | 1 | Command word available |
| cmd_ready_i | input | 1 | Engine takes the command word |
| cmd_data_o | output | 16 | Head command word |
| sdo_valid_o | output | 1 | Outgoing byte available |
| sdo_ready_i | input | 1 | Engine takes the outgoing byte |
| sdo_data_o | output | 8 | Head outgoing byte |
| sdi_valid_i | input | 1 | Engine offers an incoming byte |
| sdi_ready_o | output | 1 | Incoming byte accepted |
| sdi_data_i | input | 8 | Incoming byte |
| sync_stb_i | input | 1 | Marker completion strobe |
| sync_id_i | input | 8 | ID of the completed marker |

## Verification
The embedded properties watch the following on every clock: pending bits set, clear and stick; no queue counter overflows or underflows; the soft reset empties the queues and silences the engine handshakes; the marker ID is captured; and the interrupt stays low when nothing is enabled. Several behaviours only show up in the scenarios. These are queue ordering and the survival of entries across a dropped push, the exact room and level numbers, the threshold boundaries at occupancy 4/5 and 11/12, the non-destructive peek, and the identification word.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;

  // Register map (byte addresses)
  localparam logic [BUS_AW-1:0] OFS_VERSION  = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_SOFTRST  = 8'h40;
  localparam logic [BUS_AW-1:0] OFS_IRQ_EN   = 8'h80;
  localparam logic [BUS_AW-1:0] OFS_IRQ_PEND = 8'h84;
  localparam logic [BUS_AW-1:0] OFS_IRQ_SRC  = 8'h88;
  localparam logic [BUS_AW-1:0] OFS_SYNC_ID  = 8'hC0;
  localparam logic [BUS_AW-1:0] OFS_CMD_ROOM = 8'hD0;
  localparam logic [BUS_AW-1:0] OFS_SDO_ROOM = 8'hD4;
  localparam logic [BUS_AW-1:0] OFS_SDI_LVL  = 8'hD8;
  localparam logic [BUS_AW-1:0] OFS_CMD_PUSH = 8'hE0;
  localparam logic [BUS_AW-1:0] OFS_SDO_PUSH = 8'hE4;
  localparam logic [BUS_AW-1:0] OFS_SDI_POP  = 8'hE8;
  localparam logic [BUS_AW-1:0] OFS_SDI_PEEK = 8'hEC;

  // Interrupt source positions
  localparam int unsigned NUM_IRQ      = 4;
  localparam int unsigned IRQ_CMD_LOW  = 0;
  localparam int unsigned IRQ_SDO_LOW  = 1;
  localparam int unsigned IRQ_SDI_HIGH = 2;
  localparam int unsigned IRQ_SYNC     = 3;

  // Identification word
  localparam logic [7:0] VER_MAJOR = 8'd1;
  localparam logic [7:0] VER_MINOR = 8'd3;
  localparam logic [7:0] VER_PATCH = 8'd0;

endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; the write enable is the only control.
  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(wr_q))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> (empty_o && $stable(rd_q))); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R10

endmodule

// File: rtl/cq_irq_ctrl.sv
module cq_irq_ctrl #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] pend_q, pend_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // A set in the same cycle as a clear wins, so a live condition is never lost.
    assign pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);

    AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]); // R6
    AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R7
    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

endmodule

// File: rtl/spi_cmdq_regif.sv
module spi_cmdq_regif
  import spi_cmdq_pkg::*;
#(
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ID_W       = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned THRESH     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              eng_rst_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CMD_W-1:0]  cmd_data_o,
  output logic              sdo_valid_o,
  input  logic              sdo_ready_i,
  output logic [DATA_W-1:0] sdo_data_o,
  input  logic              sdi_valid_i,
  output logic              sdi_ready_o,
  input  logic [DATA_W-1:0] sdi_data_i,
  input  logic              sync_stb_i,
  input  logic [ID_W-1:0]   sync_id_i
);

  localparam int unsigned CNT_W   = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned HI_MARK = FIFO_DEPTH - THRESH;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  logic wr_softrst, wr_irq_en, wr_irq_pend, wr_cmd_push, wr_sdo_push, rd_sdi_pop;

  assign wr_softrst  = bus_wr_i && (bus_addr_i == OFS_SOFTRST);
  assign wr_irq_en   = bus_wr_i && (bus_addr_i == OFS_IRQ_EN);
  assign wr_irq_pend = bus_wr_i && (bus_addr_i == OFS_IRQ_PEND);
  assign wr_cmd_push = bus_wr_i && (bus_addr_i == OFS_CMD_PUSH);
  assign wr_sdo_push = bus_wr_i && (bus_addr_i == OFS_SDO_PUSH);
  assign rd_sdi_pop  = bus_rd_i && (bus_addr_i == OFS_SDI_POP);

  // Control registers
  logic               soft_rst_q, soft_rst_d;
  logic [NUM_IRQ-1:0] irq_en_q, irq_en_d;
  logic [ID_W-1:0]    sync_id_q, sync_id_d;

  always_comb begin
    soft_rst_d = soft_rst_q;
    irq_en_d   = irq_en_q;
    sync_id_d  = sync_id_q;
    if (wr_softrst) soft_rst_d = bus_wdata_i[0];
    if (wr_irq_en)  irq_en_d   = bus_wdata_i[NUM_IRQ-1:0];
    if (sync_stb_i) sync_id_d  = sync_id_i;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      soft_rst_q <= 1'b1;
      irq_en_q   <= '0;
      sync_id_q  <= '0;
    end else begin
      soft_rst_q <= soft_rst_d;
      irq_en_q   <= irq_en_d;
      sync_id_q  <= sync_id_d;
    end
  end

  // Queues
  logic [CNT_W-1:0]  cmd_cnt, sdo_cnt, sdi_cnt;
  logic              cmd_empty, cmd_full, sdo_empty, sdo_full, sdi_empty, sdi_full;
  logic [DATA_W-1:0] sdi_head;

  cq_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_cmd_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .flush_i (soft_rst_q),
    .push_i  (wr_cmd_push),
    .din_i   (bus_wdata_i[CMD_W-1:0]),
    .pop_i   (cmd_valid_o & cmd_ready_i),
    .head_o  (cmd_data_o),
    .count_o (cmd_cnt),
    .empty_o (cmd_empty),
    .full_o  (cmd_full)
  );

  cq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_sdo_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .flush_i (soft_rst_q),
    .push_i  (wr_sdo_push),
    .din_i   (bus_wdata_i[DATA_W-1:0]),
    .pop_i   (sdo_valid_o & sdo_ready_i),
    .head_o  (sdo_data_o),
    .count_o (sdo_cnt),
    .empty_o (sdo_empty),
    .full_o  (sdo_full)
  );

  cq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_sdi_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .flush_i (soft_rst_q),
    .push_i  (sdi_valid_i & sdi_ready_o),
    .din_i   (sdi_data_i),
    .pop_i   (rd_sdi_pop),
    .head_o  (sdi_head),
    .count_o (sdi_cnt),
    .empty_o (sdi_empty),
    .full_o  (sdi_full)
  );

  assign cmd_valid_o = ~cmd_empty & ~soft_rst_q;
  assign sdo_valid_o = ~sdo_empty & ~soft_rst_q;
  assign sdi_ready_o = ~sdi_full & ~soft_rst_q;
  assign eng_rst_o   = soft_rst_q;

  // Interrupt sources
  logic [NUM_IRQ-1:0] irq_cond, irq_clr, irq_pend, irq_src;

  always_comb begin
    irq_cond               = '0;
    irq_cond[IRQ_CMD_LOW]  = (cmd_cnt <= CNT_W'(THRESH));
    irq_cond[IRQ_SDO_LOW]  = (sdo_cnt <= CNT_W'(THRESH));
    irq_cond[IRQ_SDI_HIGH] = (sdi_cnt >= CNT_W'(HI_MARK));
    irq_cond[IRQ_SYNC]     = sync_stb_i;
  end

  assign irq_clr = wr_irq_pend ? bus_wdata_i[NUM_IRQ-1:0] : '0;

  cq_irq_ctrl #(.NUM_SRC(NUM_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .set_i  (irq_cond),
    .clr_i  (irq_clr),
    .en_i   (irq_en_q),
    .pend_o (irq_pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    irq_src           = irq_cond;
    irq_src[IRQ_SYNC] = irq_pend[IRQ_SYNC];
  end

  // Read path
  logic [31:0] rdata;

  always_comb begin
    rdata = '0;
    case (bus_addr_i)
      OFS_VERSION:  rdata = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
      OFS_SOFTRST:  rdata[0] = soft_rst_q;
      OFS_IRQ_EN:   rdata[NUM_IRQ-1:0] = irq_en_q;
      OFS_IRQ_PEND: rdata[NUM_IRQ-1:0] = irq_pend;
      OFS_IRQ_SRC:  rdata[NUM_IRQ-1:0] = irq_src;
      OFS_SYNC_ID:  rdata[ID_W-1:0] = sync_id_q;
      OFS_CMD_ROOM: rdata[CNT_W-1:0] = CNT_W'(FIFO_DEPTH) - cmd_cnt;
      OFS_SDO_ROOM: rdata[CNT_W-1:0] = CNT_W'(FIFO_DEPTH) - sdo_cnt;
      OFS_SDI_LVL:  rdata[CNT_W-1:0] = sdi_cnt;
      OFS_SDI_POP,
      OFS_SDI_PEEK: rdata[DATA_W-1:0] = sdi_empty ? '0 : sdi_head;
      default:      rdata = '0;
    endcase
  end

  assign bus_rdata_o = rdata;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata_i[BUS_DW-1:CMD_W], cmd_full, sdo_full};

  AST_SYNC_ID_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    sync_stb_i |=> (sync_id_q == $past(sync_id_i))); // R9
  AST_SOFTRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    soft_rst_q |-> (!cmd_valid_o && !sdo_valid_o && !sdi_ready_o)); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (irq_en_q == '0) |-> !irq_o); // R8
  AST_VALID_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    cmd_valid_o |-> (cmd_cnt != '0)); // R11

endmodule

// File: tb/spi_cmdq_regif_tb_top.sv
`timescale 1ns/1ps
module spi_cmdq_regif_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, eng_rst;
  logic        cmd_valid, cmd_ready;
  logic [15:0] cmd_data;
  logic        sdo_valid, sdo_ready;
  logic [7:0]  sdo_data;
  logic        sdi_valid, sdi_ready;
  logic [7:0]  sdi_data;
  logic        sync_stb;
  logic [7:0]  sync_id;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmdq_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .eng_rst_o(eng_rst),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data),
    .sdo_valid_o(sdo_valid), .sdo_ready_i(sdo_ready), .sdo_data_o(sdo_data),
    .sdi_valid_i(sdi_valid), .sdi_ready_o(sdi_ready), .sdi_data_i(sdi_data),
    .sync_stb_i(sync_stb), .sync_id_i(sync_id)
  );

  // {req[3:0], addr[7:0], expected[31:0]} for the state right after reset
  localparam int NRST = 13;
  localparam logic [43:0] RST_TBL [NRST] = '{
    {4'd1,  8'h00, 32'h0001_0300},  // R1 identification
    {4'd10, 8'h40, 32'h0000_0001},  // R10 held in soft reset
    {4'd8,  8'h80, 32'h0000_0000},  // R8 nothing enabled
    {4'd6,  8'h84, 32'h0000_0003},  // R6 empty queues are low
    {4'd6,  8'h88, 32'h0000_0003},  // R6 raw source
    {4'd9,  8'hC0, 32'h0000_0000},  // R9 no marker yet
    {4'd4,  8'hD0, 32'h0000_0010},  // R4 command room
    {4'd4,  8'hD4, 32'h0000_0010},  // R4 outgoing room
    {4'd4,  8'hD8, 32'h0000_0000},  // R4 incoming level
    {4'd5,  8'hE8, 32'h0000_0000},  // R5 empty pop
    {4'd5,  8'hEC, 32'h0000_0000},  // R5 empty peek
    {4'd1,  8'h10, 32'h0000_0000},  // R1 unmapped
    {4'd1,  8'hFC, 32'h0000_0000}   // R1 unmapped
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [7:0] a,
                        input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic pin_chk(input string req, input string what, input logic [31:0] act_now,
                         input logic [31:0] exp);
    chk(req, what, act_now, exp);
  endtask

  task automatic eng_take_cmd(input string req, input logic [15:0] exp);
    @(negedge clk);
    #1;
    chk(req, "cmd valid", {31'b0, cmd_valid}, 32'd1);
    chk(req, "cmd data", {16'b0, cmd_data}, {16'b0, exp});
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic eng_put_sdi(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    sdi_valid = 1'b1; sdi_data = b;
    #1 rdy = sdi_ready;
    @(negedge clk);
    sdi_valid = 1'b0;
  endtask

  task automatic eng_sync(input logic [7:0] id);
    @(negedge clk);
    sync_stb = 1'b1; sync_id = id;
    @(negedge clk);
    sync_stb = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic rdy;
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    cmd_ready = 1'b0; sdo_ready = 1'b0;
    sdi_valid = 1'b0; sdi_data = '0; sync_stb = 1'b0; sync_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    pin_chk("R10", "engine reset after power-up", {31'b0, eng_rst}, 32'd1);
    pin_chk("R8", "irq after power-up", {31'b0, irq}, 32'd0);
    pin_chk("R10", "cmd valid in reset", {31'b0, cmd_valid}, 32'd0);

    // Reset-state vector walk
    for (int i = 0; i < NRST; i++) begin
      logic [31:0] d;
      bus_read(RST_TBL[i][39:32], d);
      chk($sformatf("R%0d", RST_TBL[i][43:40]), $sformatf("reset read 0x%02h", RST_TBL[i][39:32]),
          d, RST_TBL[i][31:0]);
    end

    // R10: bus push dropped while held
    bus_write(8'hE0, 32'h0000_1234);
    rd_chk("R10", "cmd room after held push", 8'hD0, 32'd16);
    bus_write(8'h40, 32'h0);
    rd_chk("R10", "soft reset readback", 8'h40, 32'd0);
    settle();
    pin_chk("R10", "engine reset released", {31'b0, eng_rst}, 32'd0);

    // R2/R4/R11: command ordering and room
    bus_write(8'hE0, 32'hFFFF_A001);
    bus_write(8'hE0, 32'h0000_A002);
    bus_write(8'hE0, 32'h0000_A003);
    rd_chk("R4", "cmd room with 3", 8'hD0, 32'd13);
    eng_take_cmd("R2", 16'hA001);
    eng_take_cmd("R2", 16'hA002);
    eng_take_cmd("R11", 16'hA003);
    settle();
    pin_chk("R11", "cmd valid when drained", {31'b0, cmd_valid}, 32'd0);

    // R3: fill then overflow push
    for (int i = 0; i < 16; i++) bus_write(8'hE0, 32'h0100 + i);
    bus_write(8'hE0, 32'h0000_DEAD);
    rd_chk("R3", "cmd room when full", 8'hD0, 32'd0);
    for (int i = 0; i < 16; i++) eng_take_cmd("R3", 16'h0100 + 16'(i));
    settle();
    pin_chk("R3", "dropped word absent", {31'b0, cmd_valid}, 32'd0);

    // R2: outgoing byte path
    bus_write(8'hE4, 32'h0000_01AB);
    rd_chk("R4", "sdo room with 1", 8'hD4, 32'd15);
    settle();
    pin_chk("R2", "sdo data", {24'b0, sdo_data}, 32'h0000_00AB);
    pin_chk("R11", "sdo valid", {31'b0, sdo_valid}, 32'd1);
    @(negedge clk); sdo_ready = 1'b1;
    @(negedge clk); sdo_ready = 1'b0;
    rd_chk("R11", "sdo room after take", 8'hD4, 32'd16);

    // R5: incoming peek and pop
    eng_put_sdi(8'h11, rdy);
    eng_put_sdi(8'h22, rdy);
    eng_put_sdi(8'h33, rdy);
    rd_chk("R4", "sdi level 3", 8'hD8, 32'd3);
    rd_chk("R5", "peek head", 8'hEC, 32'h11);
    rd_chk("R5", "peek again", 8'hEC, 32'h11);
    rd_chk("R5", "level after peeks", 8'hD8, 32'd3);
    rd_chk("R5", "pop 1", 8'hE8, 32'h11);
    rd_chk("R5", "pop 2", 8'hE8, 32'h22);
    rd_chk("R5", "pop 3", 8'hE8, 32'h33);
    rd_chk("R5", "pop empty", 8'hE8, 32'h0);
    rd_chk("R5", "level after empty pop", 8'hD8, 32'd0);

    // R7/R8: level bits come back, masking, thresholds
    bus_write(8'h84, 32'h0000_00FF);
    rd_chk("R7", "pending re-set by live conditions", 8'h84, 32'h3);
    settle();
    pin_chk("R8", "irq with nothing enabled", {31'b0, irq}, 32'd0);
    bus_write(8'h80, 32'h1);
    settle();
    pin_chk("R8", "irq with bit0 enabled", {31'b0, irq}, 32'd1);
    for (int i = 0; i < 5; i++) bus_write(8'hE0, 32'h0200 + i);
    rd_chk("R6", "source at cmd level 5", 8'h88, 32'h2);
    bus_write(8'h84, 32'h1);
    rd_chk("R7", "pending bit0 cleared", 8'h84, 32'h2);
    settle();
    pin_chk("R8", "irq after clear", {31'b0, irq}, 32'd0);
    eng_take_cmd("R6", 16'h0200);
    rd_chk("R6", "pending at cmd level 4", 8'h84, 32'h3);
    settle();
    pin_chk("R8", "irq at threshold", {31'b0, irq}, 32'd1);
    for (int i = 1; i < 5; i++) eng_take_cmd("R2", 16'h0200 + 16'(i));

    // R6/R3/R11: incoming high mark and full
    for (int i = 0; i < 11; i++) eng_put_sdi(8'h40 + 8'(i), rdy);
    rd_chk("R6", "source at sdi level 11", 8'h88, 32'h3);
    eng_put_sdi(8'h4B, rdy);
    rd_chk("R6", "source at sdi level 12", 8'h88, 32'h7);
    for (int i = 12; i < 16; i++) eng_put_sdi(8'h40 + 8'(i), rdy);
    settle();
    pin_chk("R11", "sdi ready when full", {31'b0, sdi_ready}, 32'd0);
    eng_put_sdi(8'hEE, rdy);
    rd_chk("R3", "sdi level stays full", 8'hD8, 32'd16);
    for (int i = 0; i < 16; i++) rd_chk("R3", "sdi drain", 8'hE8, 32'h40 + i);
    bus_write(8'h84, 32'h4);
    rd_chk("R7", "pending bit2 cleared", 8'h84, 32'h3);

    // R9: marker completion
    eng_sync(8'h5A);
    rd_chk("R9", "sync id", 8'hC0, 32'h5A);
    rd_chk("R9", "pending with marker", 8'h84, 32'hB);
    bus_write(8'h80, 32'h8);
    settle();
    pin_chk("R8", "irq from marker", {31'b0, irq}, 32'd1);
    bus_write(8'h84, 32'h8);
    settle();
    pin_chk("R8", "irq masked bit0 only pending", {31'b0, irq}, 32'd0);
    eng_sync(8'hC3);
    rd_chk("R9", "sync id updated", 8'hC0, 32'hC3);

    // R10: soft reset flushes queues
    bus_write(8'hE0, 32'h0C01);
    bus_write(8'hE0, 32'h0C02);
    bus_write(8'hE4, 32'h5E);
    eng_put_sdi(8'h77, rdy);
    bus_write(8'h40, 32'h1);
    settle();
    pin_chk("R10", "engine reset high", {31'b0, eng_rst}, 32'd1);
    pin_chk("R10", "cmd valid low", {31'b0, cmd_valid}, 32'd0);
    pin_chk("R10", "sdo valid low", {31'b0, sdo_valid}, 32'd0);
    rd_chk("R10", "cmd room flushed", 8'hD0, 32'd16);
    rd_chk("R10", "sdo room flushed", 8'hD4, 32'd16);
    rd_chk("R10", "sdi level flushed", 8'hD8, 32'd0);
    eng_put_sdi(8'h99, rdy);
    chk("R10", "sdi ready in reset", {31'b0, rdy}, 32'd0);
    rd_chk("R10", "sdi level after held push", 8'hD8, 32'd0);
    bus_write(8'h40, 32'h0);
    bus_write(8'hE0, 32'h0C03);
    eng_take_cmd("R10", 16'h0C03);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule